// File: doc/BRIEF.md
# Multi-Channel General-Purpose Timer

This peripheral holds a bank of independent up-counting timers behind a simple word-wide register bus. Each channel owns a control word (run bit, a self-clearing counter-clear bit and a two-bit operating mode), a clock word (tick source and prescaler), a read-only counter and a compare value. Counting is paced by two tick-enable inputs from outside the block: a fast one and a slow one. No clock is generated here. Each channel chooses one of the two and can halve its rate.

When a counting tick arrives while a channel's counter equals its compare value, the channel latches a pending flag. In repeat mode the counter then restarts from zero. In one-shot mode the channel turns its own run bit off and holds the count. In free-run mode the counter ignores the compare value for reload and keeps counting, wrapping modulo 2^CNT_W. It can then serve as a monotonic time base. One shared register masks the pending flags onto the interrupt lines, and a second shared register clears flags when 1s are written to it and shows them when read.

Software typically clears and starts a channel with a single control write. After each interrupt it acknowledges the flag. It can stop a channel without losing its configuration.

Top module: `gptimer_bank`

## Requirements
- R1: After reset every readable register is 0, all counters are 0, and irq_o and irq_vec are low.
- R2: Byte addresses are word aligned. The interrupt-enable register is at 0x00, and bit n-1 belongs to channel n. Channel n occupies 0x10*n: control at +0x0, clock at +0x4, counter at +0x8, compare at +0xC. The control, clock, compare and enable registers read back what was written. Writes to channel n reach no other channel.
- R3: An enabled channel adds 1 per counting tick. With clock bit 4 = 0 it counts on fast_tick, and with bit 4 = 1 it counts on slow_tick. The tick input that is not selected has no effect.
- R4: With clock bit 0 = 1 the channel counts on every second selected tick. A clear write restarts the halving phase.
- R5: In repeat mode (control bits [5:4] = 1), a tick that finds the counter equal to the compare value sets the pending flag and loads the counter with 0.
- R6: In one-shot mode (control bits [5:4] = 0), the matching tick sets the pending flag, clears control bit 0 and leaves the counter at the compare value.
- R7: In free-run mode (control bits [5:4] = 3), the matching tick sets the pending flag and the counter keeps counting past the compare value.
- R8: Writing control bit 0 = 0 stops the counter. The mode, the clock word and the compare value are kept.
- R9: Writing control bit 1 = 1 zeroes the counter in that same write. Bit 1 always reads 0.
- R10: Register 0x08 reads the pending flags. Writing 1 to bit n-1 clears channel n's flag, and that clear wins over a match in the same cycle. Bits written 0 leave their flags alone, so a same-cycle match still sets them.
- R11: irq_vec is the pending flags ANDed with the enable register, and irq_o is the OR of irq_vec.
- R12: Writes to a counter address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | Fast counting-tick enable |
| slow_tick | input | 1 | Slow counting-tick enable |
| bus_wr | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_vec | output | NUM_CH | Per-channel masked interrupt |
| irq_o | output | 1 | Combined interrupt |

## Verification
Counting is driven by bursts of exact length on one tick input at a time. This shows whether the source select routes the right input and whether the prescaler halves. Small compare values exercise the three modes, and each one is told apart by what follows a match: a restart at zero, a cleared run bit with the count held, or counting straight past the compare value. Acknowledge writes are placed in the same cycle as a match, once with the matching channel's bit set and once with only another channel's bit set. This confirms that the clear takes priority only where a 1 is written. Stop, clear and counter-write stimuli are each followed by a read of the counter and the configuration words, to show what they changed and what they left alone.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   typedef enum logic [1:0] {
      MODE_ONCE = 2'd0,
      MODE_LOOP = 2'd1,
      MODE_FREE = 2'd3
   } gpt_mode_e;

   typedef enum logic [1:0] {
      SUB_CTL = 2'd0,
      SUB_CLK = 2'd1,
      SUB_CNT = 2'd2,
      SUB_CMP = 2'd3
   } gpt_sub_e;

   localparam int CTL_RUN_BIT  = 0;
   localparam int CTL_CLR_BIT  = 1;
   localparam int CTL_MODE_LSB = 4;
   localparam int CLK_SRC_BIT  = 4;
   localparam int CLK_DIV_BIT  = 0;

   localparam logic [1:0] SHARED_IEN = 2'd0;
   localparam logic [1:0] SHARED_ACK = 2'd2;

endpackage

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen #(
   parameter bit HAS_DIV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_tick,
   input  logic slow_tick,
   input  logic src_slow,
   input  logic div2,
   input  logic run,
   input  logic restart,
   output logic cnt_tick
);

   logic sel_tick;
   assign sel_tick = src_slow ? slow_tick : fast_tick;

   generate
      if (HAS_DIV) begin : g_div
         logic phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= 1'b0;
            else if (restart || !run)
               phase_q <= 1'b0;
            else if (sel_tick && div2)
               phase_q <= ~phase_q;
         end
         assign cnt_tick = run && sel_tick && (!div2 || phase_q);

         // R4: a halved tick is never followed by another in the next cycle
         a_r4_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_tick && div2) |=> (!cnt_tick || !div2));
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = div2;
         assign cnt_tick   = run && sel_tick;
      end
   endgenerate

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
   import gpt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast_tick,
   input  logic             slow_tick,
   input  logic             ctl_wr,
   input  logic             wr_run,
   input  logic             wr_clr,
   input  logic [1:0]       wr_mode,
   input  logic             clk_wr,
   input  logic             wr_src,
   input  logic             wr_div,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] wr_cmp,
   input  logic             ack_clr,
   output logic             run_o,
   output logic [1:0]       mode_o,
   output logic             src_o,
   output logic             div_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cmp_o,
   output logic             pend_o
);

   logic             run_q;
   logic [1:0]       mode_q;
   logic             src_q;
   logic             div_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_q;
   logic             pend_q;

   logic tick;
   logic hit;
   logic is_once;
   logic is_loop;
   logic clr_now;

   assign hit     = (cnt_q == cmp_q);
   assign is_once = (mode_q == MODE_ONCE);
   assign is_loop = (mode_q == MODE_LOOP);
   assign clr_now = ctl_wr && wr_clr;

   gpt_tick_gen #(.HAS_DIV(HAS_DIV)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .fast_tick(fast_tick),
      .slow_tick(slow_tick),
      .src_slow (src_q),
      .div2     (div_q),
      .run      (run_q),
      .restart  (clr_now),
      .cnt_tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mode_q <= MODE_ONCE;
      end else if (ctl_wr) begin
         run_q  <= wr_run;
         mode_q <= wr_mode;
      end else if (tick && hit && is_once) begin
         run_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         div_q <= 1'b0;
      end else if (clk_wr) begin
         src_q <= wr_src;
         div_q <= wr_div;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cmp_q <= '0;
      else if (cmp_wr)
         cmp_q <= wr_cmp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_now)
         cnt_q <= '0;
      else if (tick) begin
         if (hit && is_loop)
            cnt_q <= '0;
         else if (!(hit && is_once))
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (ack_clr)
         pend_q <= 1'b0;
      else if (tick && hit)
         pend_q <= 1'b1;
   end

   assign run_o  = run_q;
   assign mode_o = mode_q;
   assign src_o  = src_q;
   assign div_o  = div_q;
   assign cnt_o  = cnt_q;
   assign cmp_o  = cmp_q;
   assign pend_o = pend_q;

   // R5: a repeat-mode match restarts the count
   a_r5_loop_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && hit && is_loop && !ctl_wr) |=> (cnt_q == '0));

   // R6: a one-shot match stops the channel and holds the count
   a_r6_once_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && hit && is_once && !ctl_wr) |=> (!run_q && $stable(cnt_q)));

   // R7: free-run counting wraps from all ones to zero
   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !is_once && !is_loop && (cnt_q == '1) && !ctl_wr) |=> (cnt_q == '0));

   // R8: a stopped channel keeps its count
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !ctl_wr) |=> $stable(cnt_q));

   // R9: the clear bit empties the counter in the same write
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_now |=> (cnt_q == '0));

   // R10: acknowledge wins over a same-cycle match
   a_r10_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ack_clr |=> !pend_q);

endmodule

// File: rtl/gpt_decode.sv
module gpt_decode
   import gpt_pkg::*;
#(
   parameter int NUM_CH = 6,
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              aligned,
   output logic [1:0]        sub,
   output logic              shared_hit,
   output logic [NUM_CH-1:0] ch_hit
);

   localparam int SLOT_W = ADDR_W - 4;

   logic [SLOT_W-1:0] slot;

   assign slot       = addr[ADDR_W-1:4];
   assign sub        = addr[3:2];
   assign aligned    = (addr[1:0] == 2'b00);
   assign shared_hit = (slot == '0);

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_slot
         assign ch_hit[n] = (slot == SLOT_W'(n + 1));
      end
   endgenerate

endmodule

// File: rtl/gptimer_bank.sv
module gptimer_bank
   import gpt_pkg::*;
#(
   parameter int NUM_CH  = 6,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_tick,
   input  logic              slow_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq_vec,
   output logic              irq_o
);

   localparam int SLOT_W = ADDR_W - 4;

   generate
      if (NUM_CH < 1 || NUM_CH > 15) begin : g_bad_ch
         $error("gptimer_bank: NUM_CH must be 1..15");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("gptimer_bank: CNT_W must be 2..DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("gptimer_bank: DATA_W must be at least 8");
      end
      if (SLOT_W < 4 || (1 << SLOT_W) <= NUM_CH) begin : g_bad_addr
         $error("gptimer_bank: ADDR_W too small for NUM_CH slots");
      end
   endgenerate

   logic              aligned;
   logic [1:0]        sub;
   logic              shared_hit;
   logic [NUM_CH-1:0] ch_hit;

   gpt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .addr      (bus_addr),
      .aligned   (aligned),
      .sub       (sub),
      .shared_hit(shared_hit),
      .ch_hit    (ch_hit)
   );

   logic wr_ok;
   logic ien_wr;
   logic ack_wr;
   assign wr_ok  = bus_wr && aligned;
   assign ien_wr = wr_ok && shared_hit && (sub == SHARED_IEN);
   assign ack_wr = wr_ok && shared_hit && (sub == SHARED_ACK);

   logic [NUM_CH-1:0] ien_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ien_q <= '0;
      else if (ien_wr)
         ien_q <= bus_wdata[NUM_CH-1:0];
   end

   logic [NUM_CH-1:0]            run_v;
   logic [NUM_CH-1:0][1:0]       mode_v;
   logic [NUM_CH-1:0]            src_v;
   logic [NUM_CH-1:0]            div_v;
   logic [NUM_CH-1:0][CNT_W-1:0] cnt_v;
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_v;
   logic [NUM_CH-1:0]            pend_v;

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         logic sel;
         assign sel = wr_ok && ch_hit[n];

         gpt_channel #(.CNT_W(CNT_W), .HAS_DIV(HAS_DIV)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .fast_tick(fast_tick),
            .slow_tick(slow_tick),
            .ctl_wr   (sel && (sub == SUB_CTL)),
            .wr_run   (bus_wdata[CTL_RUN_BIT]),
            .wr_clr   (bus_wdata[CTL_CLR_BIT]),
            .wr_mode  (bus_wdata[CTL_MODE_LSB +: 2]),
            .clk_wr   (sel && (sub == SUB_CLK)),
            .wr_src   (bus_wdata[CLK_SRC_BIT]),
            .wr_div   (bus_wdata[CLK_DIV_BIT]),
            .cmp_wr   (sel && (sub == SUB_CMP)),
            .wr_cmp   (bus_wdata[CNT_W-1:0]),
            .ack_clr  (ack_wr && bus_wdata[n]),
            .run_o    (run_v[n]),
            .mode_o   (mode_v[n]),
            .src_o    (src_v[n]),
            .div_o    (div_v[n]),
            .cnt_o    (cnt_v[n]),
            .cmp_o    (cmp_v[n]),
            .pend_o   (pend_v[n])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (shared_hit) begin
            if (sub == SHARED_IEN)
               bus_rdata = DATA_W'(ien_q);
            else if (sub == SHARED_ACK)
               bus_rdata = DATA_W'(pend_v);
         end
         for (int n = 0; n < NUM_CH; n++) begin
            if (ch_hit[n]) begin
               case (sub)
                  SUB_CTL: begin
                     bus_rdata[CTL_RUN_BIT]        = run_v[n];
                     bus_rdata[CTL_MODE_LSB +: 2]  = mode_v[n];
                  end
                  SUB_CLK: begin
                     bus_rdata[CLK_SRC_BIT] = src_v[n];
                     bus_rdata[CLK_DIV_BIT] = div_v[n];
                  end
                  SUB_CNT: bus_rdata = DATA_W'(cnt_v[n]);
                  default: bus_rdata = DATA_W'(cmp_v[n]);
               endcase
            end
         end
      end
   end

   assign irq_vec = pend_v & ien_q;
   assign irq_o   = |irq_vec;

   // R11: acknowledging every channel drops the combined interrupt
   a_r11_ack_all: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && (&bus_wdata[NUM_CH-1:0])) |=> !irq_o);

   // R11: a masked-off bank never raises the combined interrupt
   a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq_o);

endmodule

// File: tb/gptimer_bank_bench.sv
`timescale 1ns/1ps
module gptimer_bank_bench;

   localparam int NUM_CH = 6;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;
   localparam int WATCHDOG = 200000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fast_tick = 1'b0;
   logic              slow_tick = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic [NUM_CH-1:0] irq_vec;
   logic              irq_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   gptimer_bank u_gptimer_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .fast_tick(fast_tick),
      .slow_tick(slow_tick),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq_vec  (irq_vec),
      .irq_o    (irq_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WATCHDOG) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #0.5;
      chk(req, bus_rdata, exp);
   endtask

   task automatic pulse_fast(input int n);
      @(negedge clk);
      fast_tick = 1'b1;
      repeat (n) @(negedge clk);
      fast_tick = 1'b0;
   endtask

   task automatic pulse_slow(input int n);
      @(negedge clk);
      slow_tick = 1'b1;
      repeat (n) @(negedge clk);
      slow_tick = 1'b0;
   endtask

   task automatic t_reset();
      rd_chk("R1 ien", 8'h00, 0);
      rd_chk("R1 pend", 8'h08, 0);
      rd_chk("R1 ctl1", 8'h10, 0);
      rd_chk("R1 cnt1", 8'h18, 0);
      rd_chk("R1 cmp6", 8'h6C, 0);
      chk("R1 irq", {31'd0, irq_o}, 0);
      chk("R1 irq_vec", 32'(irq_vec), 0);
   endtask

   task automatic t_map();
      wr(8'h6C, 32'hA5A5_0001);
      wr(8'h14, 32'h11);
      wr(8'h00, 32'h2A);
      rd_chk("R2 cmp6", 8'h6C, 32'hA5A5_0001);
      rd_chk("R2 cmp5 untouched", 8'h5C, 0);
      rd_chk("R2 clk1", 8'h14, 32'h11);
      rd_chk("R2 clk2 untouched", 8'h24, 0);
      rd_chk("R2 ien", 8'h00, 32'h2A);
      wr(8'h14, 0);
      wr(8'h00, 0);
   endtask

   task automatic t_source();
      wr(8'h1C, 32'hFFFF_FFFF);
      wr(8'h14, 0);
      wr(8'h10, 32'h33);
      pulse_fast(7);
      rd_chk("R3 fast count", 8'h18, 7);
      pulse_slow(3);
      rd_chk("R3 slow ignored", 8'h18, 7);
      wr(8'h14, 32'h10);
      pulse_fast(4);
      rd_chk("R3 fast ignored", 8'h18, 7);
      pulse_slow(3);
      rd_chk("R3 slow count", 8'h18, 10);
   endtask

   task automatic t_div();
      wr(8'h14, 32'h11);
      wr(8'h10, 32'h33);
      pulse_slow(10);
      rd_chk("R4 halved", 8'h18, 5);
      pulse_slow(1);
      rd_chk("R4 phase odd", 8'h18, 5);
      wr(8'h10, 32'h33);
      pulse_slow(2);
      rd_chk("R4 phase restart", 8'h18, 1);
   endtask

   task automatic t_clear();
      wr(8'h14, 0);
      pulse_fast(3);
      rd_chk("R9 before", 8'h18, 4);
      wr(8'h10, 32'h33);
      rd_chk("R9 zeroed", 8'h18, 0);
      rd_chk("R9 clr reads 0", 8'h10, 32'h31);
      pulse_fast(4);
      rd_chk("R9 resumes", 8'h18, 4);
   endtask

   task automatic t_stop();
      wr(8'h14, 32'h10);
      wr(8'h10, 32'h30);
      pulse_slow(5);
      pulse_fast(5);
      rd_chk("R8 frozen", 8'h18, 4);
      rd_chk("R8 mode kept", 8'h10, 32'h30);
      rd_chk("R8 clk kept", 8'h14, 32'h10);
      rd_chk("R8 cmp kept", 8'h1C, 32'hFFFF_FFFF);
   endtask

   task automatic t_cnt_ro();
      wr(8'h18, 32'h1234);
      rd_chk("R12 counter write ignored", 8'h18, 4);
   endtask

   task automatic t_repeat();
      wr(8'h2C, 3);
      wr(8'h20, 32'h13);
      pulse_fast(3);
      rd_chk("R5 pre-match", 8'h18 + 8'h10, 3);
      rd_chk("R5 no flag yet", 8'h08, 0);
      pulse_fast(3);
      rd_chk("R5 restarted", 8'h28, 2);
      rd_chk("R5 flag", 8'h08, 32'h02);
      wr(8'h20, 32'h10);
   endtask

   task automatic t_once();
      wr(8'h4C, 2);
      wr(8'h40, 32'h03);
      pulse_fast(3);
      pulse_fast(3);
      rd_chk("R6 held", 8'h48, 2);
      rd_chk("R6 self stop", 8'h40, 0);
      rd_chk("R6 flag", 8'h08, 32'h0A);
   endtask

   task automatic t_free();
      wr(8'h3C, 2);
      wr(8'h30, 32'h33);
      pulse_fast(5);
      rd_chk("R7 past compare", 8'h38, 5);
      rd_chk("R7 flag", 8'h08, 32'h0E);
      wr(8'h30, 32'h30);
   endtask

   task automatic t_ack();
      wr(8'h08, 32'h3F);
      rd_chk("R10 ack all", 8'h08, 0);
      wr(8'h5C, 0);
      wr(8'h50, 32'h13);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h10; fast_tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; fast_tick = 1'b0;
      rd_chk("R10 ack beats match", 8'h08, 0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h01; fast_tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; fast_tick = 1'b0;
      rd_chk("R10 zero bit lets match set", 8'h08, 32'h10);
      wr(8'h08, 32'h10);
      rd_chk("R10 plain ack", 8'h08, 0);
   endtask

   task automatic t_irq();
      wr(8'h00, 0);
      pulse_fast(1);
      rd_chk("R11 pending", 8'h08, 32'h10);
      chk("R11 masked irq", {31'd0, irq_o}, 0);
      chk("R11 masked vec", 32'(irq_vec), 0);
      wr(8'h00, 32'h10);
      @(negedge clk);
      chk("R11 irq", {31'd0, irq_o}, 1);
      chk("R11 vec", 32'(irq_vec), 32'h10);
      wr(8'h00, 32'h08);
      @(negedge clk);
      chk("R11 other mask", {31'd0, irq_o}, 0);
      wr(8'h00, 32'h10);
      wr(8'h08, 32'h10);
      @(negedge clk);
      chk("R11 acked irq", {31'd0, irq_o}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_source();
      t_div();
      t_clear();
      t_stop();
      t_cnt_ro();
      t_repeat();
      t_once();
      t_free();
      t_ack();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule